// File: doc/BRIEF.md
# ECC Flash Read Path

This block is the read side of a word-organised nonvolatile memory. Each stored word holds 16 data bits and 6 check bits. A bus asks for a byte, an aligned 16-bit word, or a 16-bit word that starts at an odd byte address. The block fetches the one or two stored words that hold the requested bytes. It runs single-error-correct, double-error-detect decoding on each fetched word, then returns the bytes with a one-cycle ready pulse and two error flags. A separate program port writes raw 22-bit codewords into the internal register array. That port is how the command logic, which lies outside this block, stores data. It is also how error patterns are planted. While the array is busy with a program or erase, no word is fetched. A pending read waits and is served once the array is free again.

The controller is a three-state machine. IDLE accepts a request on `rd_req`.
- IDLE→IDLE: the request is a byte or an aligned word and the array is free. The word is fetched at once.
- IDLE→STALL: the array is busy when the request arrives. The request is latched.
- IDLE→SPLIT: the request is a misaligned word and the array is free. The first word is fetched and its upper byte is held.
- STALL→IDLE or STALL→SPLIT: the array becomes free. The latched request is served in the same way as from IDLE.
- SPLIT→IDLE: the array is free. The second word is fetched and the response is issued.

SPLIT stays in place while the array is busy, and STALL stays in place while busy is held. `WORDS` must be a power of two.

Top module: `ecc_flash_rdpath`

## Requirements
- R1: A codeword on `pgm_code` is laid out as follows.
  - Bits [15:0] hold the data.
  - Bits [20:16] hold Hamming check bits h0..h4. Data bit i sits at the (i+1)-th integer of 3..21 that is not a power of two.
  - Check bit hk is the XOR of the data bits whose position has bit k set. Bit 16 stores h0 inverted.
  - Bit 21 is the inverse of the XOR of all data bits and the true h0..h4.
  - `pgm_we` writes `pgm_code` into word `pgm_waddr` at the clock edge. Later reads see the new word.
- R2: After reset every stored bit is 1. Any word not yet written reads as 0xFFFF with both flags low.
- R3: A word stored exactly as R1 encodes it reads back unchanged, with `rd_fixed` and `rd_fatal` low.
- R4: A single flipped bit in any of the 22 codeword bits is handled as follows.
  - The word returns its original data.
  - `rd_fixed` is high and `rd_fatal` is low.
- R5: Two flipped bits in one codeword are handled as follows.
  - `rd_fatal` is high and `rd_fixed` is low.
  - The data returned is stored bits [15:0], uncorrected.
- R6: A byte read (`rd_wide`=0) at byte address A uses word A>>1. It returns the word's low byte when A[0]=0 and its high byte when A[0]=1. The byte appears on `rd_data[7:0]` and `rd_data[15:8]`=0.
- R7: The response to a byte or aligned-word read (`rd_wide`=1, A[0]=0) accepted with the array free appears as follows.
  - `rd_ready` is high in the cycle after the request, for exactly one cycle.
  - `rd_data` holds word A>>1.
- R8: A misaligned word read (`rd_wide`=1, A[0]=1) on word N=A>>1 is served as follows.
  - The response comes two cycles after the request.
  - `rd_data[7:0]` is the high byte of word N and `rd_data[15:8]` is the low byte of word N+1.
  - N+1 wraps to 0 at the last word.
- R9: For a misaligned read, each of the two words is corrected on its own. Each flag is the OR of that flag over both words.
- R10: No word is fetched in a cycle with `array_busy` high.
  - A request made while the array is busy keeps `rd_ready` low until busy falls.
  - A misaligned read that is waiting for its second word also stays held while busy.
  - The response comes one cycle (byte or aligned) or two cycles (misaligned) after busy falls.
- R11: `rd_req` is ignored while a request is pending (STALL or SPLIT). It starts no response and does not change the pending one.
- R12: `rd_data`, `rd_fixed` and `rd_fatal` are zero in every cycle where `rd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, sampled in IDLE |
| rd_addr | input | ADDR_W (9) | Byte address of the read |
| rd_wide | input | 1 | 1 = 16-bit read, 0 = byte read |
| array_busy | input | 1 | Array is programming or erasing |
| pgm_we | input | 1 | Write enable for the raw codeword port |
| pgm_waddr | input | WA_W (8) | Word address for the write |
| pgm_code | input | 22 | Raw codeword to store |
| rd_ready | output | 1 | One-cycle response strobe |
| rd_data | output | 16 | Returned data |
| rd_fixed | output | 1 | A single-bit fault was corrected |
| rd_fatal | output | 1 | An uncorrectable fault was seen |

## Verification
Two behaviours can meet in one cycle: the busy hold and the two-part misaligned fetch. Busy can rise right after the first word of a misaligned read has been taken. A fresh request can also arrive while an earlier one is still stalled or split. The bench raises `array_busy` at chosen offsets inside SPLIT and drives a decoy `rd_req` with a different address one cycle after each pending request. It then requires exactly one ready pulse, at the cycle computed from the stall lengths, with data and flags taken from the original address.

// File: rtl/ecc_rd_pkg.sv
package ecc_rd_pkg;

    localparam int DATA_W = 16;
    localparam int HAM_W  = 5;
    localparam int CODE_W = DATA_W + HAM_W + 1;
    localparam int MAX_POS = DATA_W + HAM_W;

    // check bit 0 is stored inverted so that an all-ones word is a clean codeword
    localparam logic [HAM_W-1:0] HAM_INV = 5'b00001;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_SPLIT = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              fixed;
        logic              fatal;
    } dec_res_t;

    // Hamming position of data bit idx: the idx-th non-power-of-two from 3 upward
    function automatic int data_pos(input int idx);
        int seen;
        int res;
        seen = 0;
        res  = 0;
        for (int p = 3; p < 32; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (seen == idx && res == 0) res = p;
                seen++;
            end
        end
        return res;
    endfunction

    function automatic logic [HAM_W-1:0] ham_calc(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] c;
        int p;
        c = '0;
        for (int i = 0; i < DATA_W; i++) begin
            p = data_pos(i);
            for (int k = 0; k < HAM_W; k++) begin
                if (p[k] && d[i]) c[k] = ~c[k];
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/ecc_word_store.sv
module ecc_word_store
    import ecc_rd_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int WA_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WA_W-1:0]   wr_addr,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [WA_W-1:0]   rd_addr,
    output logic [CODE_W-1:0] rd_code
);

    logic [CODE_W-1:0] cells [WORDS];

    // erased state: every bit reads 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) cells[i] <= '1;
        end else if (wr_en) begin
            cells[wr_addr] <= wr_code;
        end
    end

    assign rd_code = cells[rd_addr];

endmodule

// File: rtl/secded_word_dec.sv
module secded_word_dec
    import ecc_rd_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output dec_res_t          res
);

    logic [DATA_W-1:0] d_raw;
    logic [DATA_W-1:0] d_fix;
    logic [HAM_W-1:0]  h_true;
    logic [HAM_W-1:0]  syn;
    logic              par_bad;
    logic              syn_zero;
    logic              syn_valid;
    logic              one_bad;
    logic              two_bad;

    always_comb begin
        d_raw     = code[DATA_W-1:0];
        h_true    = code[CODE_W-2:DATA_W] ^ HAM_INV;
        syn       = h_true ^ ham_calc(d_raw);
        par_bad   = ~(^{d_raw, h_true, code[CODE_W-1]});
        syn_zero  = (syn == '0);
        syn_valid = (int'(syn) <= MAX_POS);
        one_bad   = par_bad && syn_valid;
        two_bad   = (!par_bad && !syn_zero) || (par_bad && !syn_valid);
    end

    // one flip gate per data bit, keyed by that bit's Hamming position
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_fix
        localparam int POS = data_pos(gi);
        assign d_fix[gi] = d_raw[gi] ^ (one_bad && (syn == HAM_W'(POS)));
    end

    assign res.data  = two_bad ? d_raw : d_fix;
    assign res.fixed = one_bad;
    assign res.fatal = two_bad;

endmodule

// File: rtl/ecc_rd_ctrl.sv
module ecc_rd_ctrl
    import ecc_rd_pkg::*;
#(
    parameter int ADDR_W = 9,
    localparam int WA_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_wide,
    input  logic              busy,
    input  dec_res_t          dec,
    output logic              fetch_en,
    output logic [WA_W-1:0]   fetch_waddr,
    output logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fixed,
    output logic              rd_fatal
);

    rd_state_e         state_q;
    rd_state_e         state_d;
    logic [ADDR_W-1:0] lat_addr;
    logic              lat_wide;
    logic [ADDR_W-1:0] sel_addr;
    logic              sel_wide;
    logic              sel_misal;
    logic              serve_first;
    logic              serve_second;
    logic [7:0]        hold_byte;
    logic              hold_fixed;
    logic              hold_fatal;

    always_comb begin
        sel_addr     = (state_q == ST_IDLE) ? rd_addr : lat_addr;
        sel_wide     = (state_q == ST_IDLE) ? rd_wide : lat_wide;
        sel_misal    = sel_wide && sel_addr[0];
        serve_first  = !busy && ((state_q == ST_IDLE && rd_req) || state_q == ST_STALL);
        serve_second = !busy && (state_q == ST_SPLIT);
        fetch_en     = serve_first || serve_second;
        fetch_waddr  = serve_second ? (lat_addr[ADDR_W-1:1] + WA_W'(1))
                                    : sel_addr[ADDR_W-1:1];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_req) begin
                    if (busy)           state_d = ST_STALL;
                    else if (sel_misal) state_d = ST_SPLIT;
                end
            end
            ST_STALL: begin
                if (!busy) state_d = sel_misal ? ST_SPLIT : ST_IDLE;
            end
            ST_SPLIT: begin
                if (!busy) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ready   <= 1'b0;
            rd_data    <= '0;
            rd_fixed   <= 1'b0;
            rd_fatal   <= 1'b0;
            lat_addr   <= '0;
            lat_wide   <= 1'b0;
            hold_byte  <= '0;
            hold_fixed <= 1'b0;
            hold_fatal <= 1'b0;
        end else begin
            rd_ready <= 1'b0;
            rd_data  <= '0;
            rd_fixed <= 1'b0;
            rd_fatal <= 1'b0;
            if (state_q == ST_IDLE && rd_req) begin
                lat_addr <= rd_addr;
                lat_wide <= rd_wide;
            end
            if (serve_first && sel_misal) begin
                hold_byte  <= dec.data[15:8];
                hold_fixed <= dec.fixed;
                hold_fatal <= dec.fatal;
            end else if (serve_first) begin
                rd_ready <= 1'b1;
                rd_fixed <= dec.fixed;
                rd_fatal <= dec.fatal;
                if (sel_wide)         rd_data <= dec.data;
                else if (sel_addr[0]) rd_data <= {8'h00, dec.data[15:8]};
                else                  rd_data <= {8'h00, dec.data[7:0]};
            end else if (serve_second) begin
                rd_ready <= 1'b1;
                rd_data  <= {dec.data[7:0], hold_byte};
                rd_fixed <= hold_fixed | dec.fixed;
                rd_fatal <= hold_fatal | dec.fatal;
            end
        end
    end

    // R10
    ready_not_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> !$past(busy));

    // R10
    stall_holds_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STALL && busy) |=> !rd_ready);

    // R7
    aligned_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rd_req && !busy && !(rd_wide && rd_addr[0])) |=> rd_ready);

    // R8
    split_first_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serve_first && sel_misal) |=> (!rd_ready && state_q == ST_SPLIT));

    // R8
    split_second_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SPLIT && !busy) |=> (rd_ready && state_q == ST_IDLE));

    // R12
    idle_outputs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ready |-> (rd_data == '0 && !rd_fixed && !rd_fatal));

    // R5
    dec_flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |-> !(dec.fixed && dec.fatal));

endmodule

// File: rtl/ecc_flash_rdpath.sv
module ecc_flash_rdpath
    import ecc_rd_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int WA_W = $clog2(WORDS),
    localparam int ADDR_W = WA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_wide,
    input  logic              array_busy,
    input  logic              pgm_we,
    input  logic [WA_W-1:0]   pgm_waddr,
    input  logic [CODE_W-1:0] pgm_code,
    output logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_fixed,
    output logic              rd_fatal
);

    logic              fetch_en;
    logic [WA_W-1:0]   fetch_waddr;
    logic [CODE_W-1:0] fetch_code;
    dec_res_t          dec;

    ecc_word_store #(.WORDS(WORDS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pgm_we),
        .wr_addr (pgm_waddr),
        .wr_code (pgm_code),
        .rd_addr (fetch_waddr),
        .rd_code (fetch_code)
    );

    secded_word_dec u_dec (
        .code (fetch_code),
        .res  (dec)
    );

    ecc_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_req      (rd_req),
        .rd_addr     (rd_addr),
        .rd_wide     (rd_wide),
        .busy        (array_busy),
        .dec         (dec),
        .fetch_en    (fetch_en),
        .fetch_waddr (fetch_waddr),
        .rd_ready    (rd_ready),
        .rd_data     (rd_data),
        .rd_fixed    (rd_fixed),
        .rd_fatal    (rd_fatal)
    );

    // R10
    no_fetch_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        array_busy |=> !rd_ready || $past(fetch_en) == 1'b0 || 1'b0 == $past(array_busy));

endmodule

// File: tb/tb_ecc_flash_rdpath.sv
module tb_ecc_flash_rdpath;

    localparam int WORDS  = 256;
    localparam int ADDR_W = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_req = 1'b0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic              rd_wide = 1'b0;
    logic              array_busy = 1'b0;
    logic              pgm_we = 1'b0;
    logic [7:0]        pgm_waddr = '0;
    logic [21:0]       pgm_code = '0;
    logic              rd_ready;
    logic [15:0]       rd_data;
    logic              rd_fixed;
    logic              rd_fatal;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [15:0] sh_true [WORDS];
    logic [21:0] sh_code [WORDS];
    int          sh_kind [WORDS];

    always #10 clk = ~clk;

    ecc_flash_rdpath dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_wide(rd_wide), .array_busy(array_busy), .pgm_we(pgm_we),
        .pgm_waddr(pgm_waddr), .pgm_code(pgm_code), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_fixed(rd_fixed), .rd_fatal(rd_fatal)
    );

    // R1 encoder: XOR of positions of set data bits gives the check field
    function automatic logic [21:0] enc(input logic [15:0] d);
        logic [4:0] h;
        logic [21:0] cw;
        int n;
        h = '0;
        n = 0;
        for (int p = 1; p <= 21; p++) begin
            if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
                if (d[n]) h = h ^ p[4:0];
                n++;
            end
        end
        cw[15:0]  = d;
        cw[20:16] = h ^ 5'b00001;
        cw[21]    = ~((^d) ^ (^h));
        return cw;
    endfunction

    function automatic logic [15:0] exp_word(input int w);
        return (sh_kind[w] == 2) ? sh_code[w][15:0] : sh_true[w];
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put(input int w, input logic [15:0] d, input int kind,
                       input int b0, input int b1);
        logic [21:0] cw;
        cw = enc(d);
        if (kind >= 1) cw[b0] = ~cw[b0];
        if (kind == 2) cw[b1] = ~cw[b1];
        pgm_we    = 1'b1;
        pgm_waddr = w[7:0];
        pgm_code  = cw;
        @(negedge clk);
        pgm_we    = 1'b0;
        sh_true[w] = d;
        sh_code[w] = cw;
        sh_kind[w] = kind;
    endtask

    task automatic read_op(input string req, input int addr, input bit wide,
                           input int stall, input int split_stall);
        int w, w2, lat, first, pulses;
        bit misal, rogue;
        logic [15:0] ed, gd;
        logic ef, ex, gf, gx;
        w     = (addr >> 1) % WORDS;
        misal = wide && addr[0];
        w2    = (w + 1) % WORDS;
        if (misal) begin
            ed  = {exp_word(w2)[7:0], exp_word(w)[15:8]};
            ef  = (sh_kind[w] == 1) || (sh_kind[w2] == 1);
            ex  = (sh_kind[w] == 2) || (sh_kind[w2] == 2);
            lat = stall + 2 + split_stall;
        end else begin
            if (wide)         ed = exp_word(w);
            else if (addr[0]) ed = {8'h00, exp_word(w)[15:8]};
            else              ed = {8'h00, exp_word(w)[7:0]};
            ef  = (sh_kind[w] == 1);
            ex  = (sh_kind[w] == 2);
            lat = stall + 1;
        end
        rogue  = (stall > 0) || misal;
        first  = -1;
        pulses = 0;
        gd = '0; gf = 1'b0; gx = 1'b0;
        for (int c = 0; c <= lat + 3; c++) begin
            if (c > 0) begin
                @(negedge clk);
                if (rd_ready) begin
                    pulses++;
                    if (first < 0) begin
                        first = c; gd = rd_data; gf = rd_fixed; gx = rd_fatal;
                    end
                end else if (rd_data != 16'h0 || rd_fixed || rd_fatal) begin
                    check("R12", "quiet outputs", {rd_data, 14'h0, rd_fixed, rd_fatal}, 32'h0);
                end
            end
            rd_req     = (c == 0) || (c == 1 && rogue);
            rd_addr    = (c == 0) ? addr[ADDR_W-1:0] : (addr[ADDR_W-1:0] ^ 9'h0A5);
            rd_wide    = (c == 0) ? wide : ~wide;
            array_busy = (c < stall) ||
                         (misal && c >= stall + 1 && c < stall + 1 + split_stall);
        end
        rd_req = 1'b0;
        array_busy = 1'b0;
        // R11: decoy request while pending must not add a response
        check("R11", "ready pulses", pulses, 1);
        check(stall > 0 ? "R10" : (misal ? "R8" : "R7"), "latency", first, lat);
        check(req, "data", {16'h0, gd}, {16'h0, ed});
        check(req, "fixed flag", {31'h0, gf}, {31'h0, ef});
        check(req, "fatal flag", {31'h0, gx}, {31'h0, ex});
    endtask

    initial begin : watchdog
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                finished = 1'b1;
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin : main
        int unsigned seed;
        for (int i = 0; i < WORDS; i++) begin
            sh_true[i] = 16'hFFFF; sh_code[i] = '1; sh_kind[i] = 0;
        end
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R2 / R12: reset state at the ports
        check("R2", "ready after reset", {31'h0, rd_ready}, 32'h0);
        check("R12", "data after reset", {16'h0, rd_data}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: erased words read all ones, clean
        read_op("R2", 400, 1'b1, 0, 0);
        read_op("R2", 13, 1'b0, 0, 0);

        // R1, R3, R7: clean aligned reads
        put(5, 16'h1234, 0, 0, 0);
        put(6, 16'hA5C3, 0, 0, 0);
        put(7, 16'h0000, 0, 0, 0);
        read_op("R3", 10, 1'b1, 0, 0);
        read_op("R1", 14, 1'b1, 0, 0);
        // R6: both byte lanes
        read_op("R6", 12, 1'b0, 0, 0);
        read_op("R6", 13, 1'b0, 0, 0);
        // R8: misaligned across words 5 and 6
        read_op("R8", 11, 1'b1, 0, 0);
        // R8: wrap from last word to word 0
        put(0, 16'hBEEF, 0, 0, 0);
        put(WORDS - 1, 16'h7E81, 0, 0, 0);
        read_op("R8", 2 * WORDS - 1, 1'b1, 0, 0);

        // R4: every single-bit position
        for (int b = 0; b < 22; b++) begin
            put(20, 16'h5A3C ^ 16'(b), 1, b, 0);
            read_op("R4", 40, 1'b1, 0, 0);
        end
        // R5: double faults, data and check bits mixed
        put(21, 16'hC0DE, 2, 3, 9);
        read_op("R5", 42, 1'b1, 0, 0);
        put(21, 16'h0F0F, 2, 17, 21);
        read_op("R5", 42, 1'b1, 0, 0);
        // R9: misaligned, one half corrected, other half fatal
        put(30, 16'h1122, 1, 12, 0);
        put(31, 16'h3344, 2, 0, 15);
        read_op("R9", 61, 1'b1, 0, 0);
        put(31, 16'h3344, 0, 0, 0);
        read_op("R9", 61, 1'b1, 0, 0);

        // R10 / R11: stall before service, and busy inside the split
        read_op("R10", 10, 1'b1, 3, 0);
        read_op("R10", 11, 1'b1, 2, 3);
        read_op("R11", 61, 1'b1, 0, 2);
        read_op("R10", 13, 1'b0, 1, 0);

        // randomized mix
        for (int it = 0; it < 300; it++) begin
            int w, kind, b0, b1, addr, st, ss;
            int unsigned r;
            r    = $urandom;
            w    = int'(r % WORDS);
            kind = int'(($urandom % 4 == 3) ? 2 : ($urandom % 3 == 0 ? 1 : 0));
            b0   = int'($urandom % 22);
            b1   = (b0 + 1 + int'($urandom % 21)) % 22;
            put(w, 16'($urandom), kind, b0, b1);
            addr = (2 * w + int'($urandom % 3)) % (2 * WORDS);
            st   = int'($urandom % 3);
            ss   = int'($urandom % 2);
            read_op(kind == 2 ? "R5" : (kind == 1 ? "R4" : "R3"),
                    addr, 1'($urandom), st, ss);
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule